// File: doc/BRIEF.md
# Latched Serial Command Port Expander

This block lets a small microcontroller drive a wide bank of general-purpose outputs over only three serial wires: a bit clock, a data line and an end strobe. The host shifts a short command word into a staging register, one bit per falling edge of the bit clock, with the least significant bit first. Nothing visible changes while bits are being shifted. Only a falling edge on the end strobe makes the block decode the staged word and apply it.

A command either sets or clears one output bit, or picks one of two expansion full-duplex serial channels. The chosen channel is wired straight through to the host UART pins. Because outputs move only when the strobe is given on purpose, a host that resets, crashes or toggles the bit clock by accident cannot glitch the relays or lamps hanging off the outputs.

All three link inputs are asynchronous to the system clock. They pass through two-flop synchronisers, and their edges are detected in the system clock domain.

Top module: `serial_cmd_expander`

## Requirements
- R1: After synchronous reset, every output in `gpo_o` is low, `chan_sel_o` is 0 (expansion channel 1) and the staging register holds zero. A strobe with no bits shifted therefore applies code 0x00.
- R2: Each falling edge of `sclk_i` shifts the data bit into the most significant position of the 6-bit staging register and moves the older bits one place toward bit 0. A frame sent least significant bit first over six clocks lands with its first bit in bit 0.
- R3: A committed code from 0x00 to 0x1C drives output bit N high, where N equals the code.
- R4: A committed code from 0x20 to 0x3C drives output bit N low, where N equals the code minus 0x20.
- R5: Committed code 0x3F sets `chan_sel_o` to 1 (channel 2). Committed code 0x3E sets it to 0 (channel 1).
- R6: Committed codes 0x1D, 0x1E, 0x1F and 0x3D leave both the outputs and the channel select unchanged.
- R7: The outputs and the channel select change only on a falling edge of `strobe_i`. Shifted bits, partial frames and rising strobe edges leave them unchanged.
- R8: A strobe does not clear the staging register. Bits shifted after a commit combine with the bits that remain from the previous frame.
- R9: With `chan_sel_o` at 0, `host_rxd_o` follows `exp0_rxd_i`, `exp0_txd_o` follows `host_txd_i` and `exp1_txd_o` sits at idle high. With `chan_sel_o` at 1, the roles of the two channels swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock from host, idles high |
| sdata_i | input | 1 | Serial data from host |
| strobe_i | input | 1 | End strobe from host, idles high, falling edge commits |
| host_txd_i | input | 1 | Host UART transmit line |
| host_rxd_o | output | 1 | Host UART receive line |
| exp0_rxd_i | input | 1 | Expansion channel 1 receive |
| exp0_txd_o | output | 1 | Expansion channel 1 transmit |
| exp1_rxd_i | input | 1 | Expansion channel 2 receive |
| exp1_txd_o | output | 1 | Expansion channel 2 transmit |
| chan_sel_o | output | 1 | Selected expansion channel (0 = channel 1, 1 = channel 2) |
| gpo_o | output | NUM_OUT | Latched general-purpose outputs |

## Verification
The bench builds the block with its defaults: FRAME_W = 6, NUM_OUT = 29 and two synchroniser stages. With these values every set and clear code is reachable, including the top output bit 28. The unused codes in the gaps between the set, clear and select ranges are also reachable. A 6-bit frame makes partial-frame commits short enough to reason about, so the bench can check exactly how leftover staging bits combine with new ones.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET,
        OP_CLR,
        OP_SEL_A,
        OP_SEL_B
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e    op;
        logic [7:0] idx;
    } cmd_dec_t;

    typedef struct packed {
        logic sclk;
        logic sdat;
        logic stb;
    } link_t;

    function automatic cmd_dec_t decode_cmd(logic [15:0] code,
                                            int unsigned fw,
                                            int unsigned nout);
        cmd_dec_t    d;
        int unsigned c;
        int unsigned clr_base;
        int unsigned top;
        c        = int'(code);
        clr_base = 1 << (fw - 1);
        top      = (1 << fw) - 1;
        d.op     = OP_NONE;
        d.idx    = '0;
        if (c == top) begin
            d.op = OP_SEL_B;
        end else if (c == top - 1) begin
            d.op = OP_SEL_A;
        end else if (c < clr_base) begin
            if (c < nout) begin
                d.op  = OP_SET;
                d.idx = 8'(c);
            end
        end else if ((c - clr_base) < nout) begin
            d.op  = OP_CLR;
            d.idx = 8'(c - clr_base);
        end
        return d;
    endfunction

endpackage

// File: rtl/cmdx_sync.sv
module cmdx_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cmdx_shift.sv
module cmdx_shift #(
    parameter int FRAME_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  cmdx_pkg::link_t    link_i,
    output logic [FRAME_W-1:0] code_o,
    output logic               commit_o
);

    logic               sclk_prev_q;
    logic               stb_prev_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               sclk_fall;

    assign sclk_fall = sclk_prev_q & ~link_i.sclk;
    assign commit_o  = stb_prev_q & ~link_i.stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b1;
            stb_prev_q  <= 1'b1;
            shreg_q     <= '0;
        end else begin
            sclk_prev_q <= link_i.sclk;
            stb_prev_q  <= link_i.stb;
            if (sclk_fall) shreg_q <= {link_i.sdat, shreg_q[FRAME_W-1:1]};
        end
    end

    assign code_o = shreg_q;

    // R2: staging contents move only on a bit-clock falling edge
    p_shift_only_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(shreg_q));

    // R2: incoming bit lands at the top position
    p_new_bit_top_r2: assert property (@(posedge clk) disable iff (rst)
        sclk_fall |=> shreg_q[FRAME_W-1] == $past(link_i.sdat));

endmodule

// File: rtl/cmdx_commit.sv
module cmdx_commit #(
    parameter int FRAME_W = 6,
    parameter int NUM_OUT = 29
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit_i,
    input  logic [FRAME_W-1:0] code_i,
    output logic [NUM_OUT-1:0] gpo_o,
    output logic               sel_o
);
    import cmdx_pkg::*;

    localparam int unsigned ALL_ONES = (1 << FRAME_W) - 1;

    cmd_dec_t           dec;
    logic [NUM_OUT-1:0] gpo_q;
    logic               sel_q;

    assign dec = decode_cmd(16'(code_i), FRAME_W, NUM_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            gpo_q <= '0;
            sel_q <= 1'b0;
        end else if (commit_i) begin
            case (dec.op)
                OP_SEL_A: sel_q <= 1'b0;
                OP_SEL_B: sel_q <= 1'b1;
                default:  ;
            endcase
            for (int i = 0; i < NUM_OUT; i++) begin
                if (dec.idx == 8'(i)) begin
                    if (dec.op == OP_SET) gpo_q[i] <= 1'b1;
                    if (dec.op == OP_CLR) gpo_q[i] <= 1'b0;
                end
            end
        end
    end

    assign gpo_o = gpo_q;
    assign sel_o = sel_q;

    // R7: latch holds without a strobe falling edge
    p_hold_without_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> ($stable(gpo_q) && $stable(sel_q)));

    // R6: codes outside the defined ranges change nothing
    p_unused_code_r6: assert property (@(posedge clk) disable iff (rst)
        (commit_i && dec.op == OP_NONE) |=> ($stable(gpo_q) && $stable(sel_q)));

    // R5: all-ones code selects channel 2
    p_sel_second_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_i && int'(code_i) == ALL_ONES) |=> sel_q);

    // R5: all-ones minus one selects channel 1
    p_sel_first_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_i && int'(code_i) == ALL_ONES - 1) |=> !sel_q);

    // R3/R4: at most one output bit moves per commit
    p_single_bit_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(gpo_q ^ $past(gpo_q)) <= 1);

endmodule

// File: rtl/cmdx_uart_route.sv
module cmdx_uart_route (
    input  logic sel_i,
    input  logic host_txd_i,
    output logic host_rxd_o,
    input  logic exp0_rxd_i,
    output logic exp0_txd_o,
    input  logic exp1_rxd_i,
    output logic exp1_txd_o
);

    always_comb begin
        host_rxd_o = sel_i ? exp1_rxd_i : exp0_rxd_i;
        exp0_txd_o = sel_i ? 1'b1 : host_txd_i;
        exp1_txd_o = sel_i ? host_txd_i : 1'b1;
    end

endmodule

// File: rtl/serial_cmd_expander.sv
module serial_cmd_expander #(
    parameter int FRAME_W     = 6,
    parameter int NUM_OUT     = 29,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_i,
    input  logic               sdata_i,
    input  logic               strobe_i,
    input  logic               host_txd_i,
    output logic               host_rxd_o,
    input  logic               exp0_rxd_i,
    output logic               exp0_txd_o,
    input  logic               exp1_rxd_i,
    output logic               exp1_txd_o,
    output logic               chan_sel_o,
    output logic [NUM_OUT-1:0] gpo_o
);
    import cmdx_pkg::*;

    localparam int LINK_W = $bits(link_t);

    link_t              link_raw;
    link_t              link_s;
    logic [LINK_W-1:0]  link_sync_q;
    logic [FRAME_W-1:0] code;
    logic               commit;

    assign link_raw = '{sclk: sclk_i, sdat: sdata_i, stb: strobe_i};

    cmdx_sync #(
        .W       (LINK_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINK_W'(3'b101))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (link_raw),
        .q_o (link_sync_q)
    );

    assign link_s = link_sync_q;

    cmdx_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .link_i   (link_s),
        .code_o   (code),
        .commit_o (commit)
    );

    cmdx_commit #(.FRAME_W(FRAME_W), .NUM_OUT(NUM_OUT)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .code_i   (code),
        .gpo_o    (gpo_o),
        .sel_o    (chan_sel_o)
    );

    cmdx_uart_route u_route (
        .sel_i      (chan_sel_o),
        .host_txd_i (host_txd_i),
        .host_rxd_o (host_rxd_o),
        .exp0_rxd_i (exp0_rxd_i),
        .exp0_txd_o (exp0_txd_o),
        .exp1_rxd_i (exp1_rxd_i),
        .exp1_txd_o (exp1_txd_o)
    );

    // R1: reset leaves outputs low and channel 1 selected
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (gpo_o == '0 && !chan_sel_o));

    // R9: unselected expansion transmit line idles high
    p_idle_unselected_r9: assert property (@(posedge clk) disable iff (rst)
        chan_sel_o ? exp0_txd_o : exp1_txd_o);

endmodule

// File: tb/sim_serial_cmd_expander.sv
module sim_serial_cmd_expander;

    localparam int CLK_PERIOD = 10;
    localparam int NOUT       = 29;
    localparam int HOLD       = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sclk = 1'b1, sdat = 1'b0, stb = 1'b1;
    logic            htx = 1'b1, e0rx = 1'b1, e1rx = 1'b1;
    logic            hrx, e0tx, e1tx, sel;
    logic [NOUT-1:0] gpo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [NOUT-1:0] m_gpo = '0;
    logic            m_sel = 1'b0;

    logic [NOUT-1:0] q_gpo [$];
    logic            q_sel [$];
    string           q_tag [$];
    event            chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_expander u0 (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdat), .strobe_i(stb),
        .host_txd_i(htx), .host_rxd_o(hrx), .exp0_rxd_i(e0rx), .exp0_txd_o(e0tx),
        .exp1_rxd_i(e1rx), .exp1_txd_o(e1tx), .chan_sel_o(sel), .gpo_o(gpo));

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check1(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Requirement model: applies a committed code to the expected state
    function automatic void model(int code);
        if (code == 63)                       m_sel = 1'b1;
        else if (code == 62)                  m_sel = 1'b0;
        else if (code < 32 && code < NOUT)    m_gpo[code] = 1'b1;
        else if (code >= 32 && code - 32 < NOUT) m_gpo[code-32] = 1'b0;
    endfunction

    task automatic shift_bits(int code, int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdat = code[i];
            wait_cyc(HOLD);
            sclk = 1'b0;
            wait_cyc(HOLD);
            sclk = 1'b1;
            wait_cyc(HOLD);
        end
    endtask

    task automatic strobe_pulse();
        stb = 1'b0;
        wait_cyc(HOLD);
        stb = 1'b1;
        wait_cyc(HOLD + 4);
    endtask

    task automatic expect_now(string tag);
        q_gpo.push_back(m_gpo);
        q_sel.push_back(m_sel);
        q_tag.push_back(tag);
        -> chk_ev;
        wait_cyc(1);
    endtask

    // driver: full frame then commit, model applies the code
    task automatic send_cmd(int code, string tag);
        shift_bits(code, 6);
        strobe_pulse();
        model(code);
        expect_now(tag);
    endtask

    task automatic check_route(string tag);
        for (int v = 0; v < 8; v++) begin
            htx = v[0]; e0rx = v[1]; e1rx = v[2];
            #1;
            check1({tag, " rxd"}, hrx, m_sel ? e1rx : e0rx);
            check1({tag, " tx0"}, e0tx, m_sel ? 1'b1 : htx);
            check1({tag, " tx1"}, e1tx, m_sel ? htx : 1'b1);
        end
        htx = 1'b1; e0rx = 1'b1; e1rx = 1'b1;
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q_gpo.size() > 0) begin
                logic [NOUT-1:0] eg;
                logic            es;
                string           t;
                eg = q_gpo.pop_front();
                es = q_sel.pop_front();
                t  = q_tag.pop_front();
                n_checks++;
                if (gpo !== eg || sel !== es) begin
                    n_fail++;
                    $display("FAIL %s: actual gpo=%h sel=%b expected gpo=%h sel=%b",
                             t, gpo, sel, eg, es);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        expect_now("R1 reset state");
        check_route("R9 after reset");

        // R1: staging is zero after reset, a bare strobe applies code 0
        strobe_pulse(); model(0); expect_now("R1 staging cleared");

        send_cmd(8'h02, "R3 set bit 2");
        send_cmd(8'h04, "R3 set bit 4");

        // R8/R2: one more bit over leftover 000100 gives 100010 = clear bit 2
        shift_bits(1, 1);
        strobe_pulse(); model(8'h22); expect_now("R8 leftover staging bits");

        send_cmd(8'h1C, "R3 set top bit 28");
        send_cmd(8'h15, "R2 bit order set bit 21");

        // R7: full frame and partial frame without strobe change nothing
        shift_bits(8'h20, 6);
        expect_now("R7 frame without strobe");
        shift_bits(8'h3F, 3);
        stb = 1'b1; wait_cyc(4);
        expect_now("R7 stray clocks");

        send_cmd(8'h20, "R4 clear bit 0");
        send_cmd(8'h3C, "R4 clear top bit 28");

        send_cmd(8'h1D, "R6 code 0x1D");
        send_cmd(8'h1E, "R6 code 0x1E");
        send_cmd(8'h1F, "R6 code 0x1F");
        send_cmd(8'h3D, "R6 code 0x3D");

        send_cmd(8'h3F, "R5 select channel 2");
        check_route("R9 channel 2");
        send_cmd(8'h3E, "R5 select channel 1");
        check_route("R9 channel 1");

        for (int b = 0; b < NOUT; b += 3) send_cmd(b, "R3 sweep set");
        for (int b = 0; b < NOUT; b += 6) send_cmd(32 + b, "R4 sweep clear");

        wait_cyc(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule